// File: doc/BRIEF.md
# Priority Override Channel Scheduler

This block decides which channel context the transmitter serves next. In normal operation it steps round-robin through a table of `NUM_CTX` channel contexts and advances one position each time the transmitter reports that the current channel's service is done. The host can request priority service by setting a request bit. The scheduler does not interrupt the channel in flight. When that channel completes, it switches to a host-built priority list held in memory and walks the list one 16-bit word at a time through a request/valid read port. Each entry flagged active is served in turn. Inactive entries are passed over.

When the list ends, the hardware clears the request bit and the scheduler goes back to the normal table. The list ends either at an entry that carries the end flag or after the last entry the list can hold. On return, the normal walk continues at the position it would have reached had the interruption never happened. That position is the successor of the channel that completed when the walk began. The stored normal position is frozen for the whole priority walk.

Top module: `pos_sched`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the scheduler enters normal mode. After that edge `serve_idx` is 0, `serve_vld` is 1, `serve_prio` is 0, `prio_req` is 0 and `rd_req` is 0. This holds even if a priority walk was in progress.
- R2: In normal mode, each cycle with `svc_done` high advances `serve_idx` by one from the next cycle on. After index `NUM_CTX-1` it wraps to 0.
- R3: A cycle with `prio_set` high makes `prio_req` read 1 from the next cycle. The normal channel being served keeps its index and mode until its `svc_done` arrives. Only then does the priority walk begin.
- R4: While fetching entry n, counted from 0 at each walk start, the scheduler drives `rd_req` = 1, `serve_vld` = 0 and `rd_addr` = `LIST_BASE` + 2·n. Both outputs hold stable until a cycle with `rd_valid` high, which is the only cycle in which `rd_data` is taken.
- R5: An entry's fields are decoded as follows: bits 15:3 are the context index, bit 1 is the end flag, bit 0 is the active flag, and bit 2 is ignored. An active entry is served with `serve_prio` = 1, `serve_vld` = 1 and `serve_idx` equal to its index. The entry stays in service until `svc_done`.
- R6: An entry with bit 0 clear is never presented for service. The next entry is fetched directly.
- R7: The entry carrying the end flag is the last one read. If it is active, it is served first. If it is inactive, the walk ends right after it is read.
- R8: If no entry carries the end flag, the walk ends after entry `LIST_MAX-1`, so exactly `LIST_MAX` words are read.
- R9: When the walk ends, `prio_req` reads 0 in the next cycle. In that same cycle the scheduler is back in normal mode, with `serve_idx` equal to the successor (mod `NUM_CTX`) of the channel whose completion started the walk.
- R10: The normal-table position does not change during a priority walk. A `svc_done` pulse while an entry is being fetched has no effect on the fetch, on the list position or on the normal position.
- R11: If `prio_set` is high in the cycle the walk ends, the request stays pending and `prio_req` remains 1. The scheduler returns to normal mode. The next normal `svc_done` starts a new walk from entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prio_set | input | 1 | Host write pulse that sets the priority request bit |
| prio_req | output | 1 | Priority request bit; cleared by hardware at walk end |
| svc_done | input | 1 | Transmitter has finished serving the current channel |
| serve_vld | output | 1 | `serve_idx` is a valid channel to serve |
| serve_prio | output | 1 | The channel being served comes from the priority list |
| serve_idx | output | 13 | Context index to serve |
| rd_req | output | 1 | Read request to the priority list |
| rd_addr | output | ADDR_W | Byte address of the list word requested |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 16 | List word returned by the read |

## Verification
The host setting the request bit and the hardware clearing it at walk end can land in the same cycle. The bench provokes this by raising `prio_set` together with the `svc_done` that completes the last priority entry. It then expects `prio_req` to stay 1, the normal channel to be presented, and the following normal completion to start a second fetch at the list base. A second coincidence is a transmitter completion that arrives while a list word is still outstanding. The bench judges that case by checking that the same entry is still served afterwards and that the normal position advanced only once.

// File: rtl/pos_sched_pkg.sv
// Package: shared types of the priority override channel scheduler.
// Assumes list words are 16 bits wide with a fixed field layout.
package pos_sched_pkg;

    localparam int CTX_W = 13;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_FETCH = 2'd1,
        WALK_SERVE = 2'd2
    } walk_state_e;

    // One priority list word: index, ignored bit, end flag, active flag.
    typedef struct packed {
        logic [CTX_W-1:0] ctx;
        logic             spare;
        logic             last;
        logic             active;
    } prio_entry_t;

endpackage

// File: rtl/pos_ctx_ring.sv
// Module: round-robin pointer into the normal context table.
// It advances by one on each adv pulse and wraps after NUM_CTX-1.
// Because it only moves on adv, it also serves as the saved position
// while a priority walk is running.
// Assumes 1 <= NUM_CTX <= 2**CTX_W.
module pos_ctx_ring #(
    parameter int NUM_CTX = 8,
    parameter int CTX_W   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [CTX_W-1:0] ptr
);
    localparam logic [CTX_W-1:0] LAST_POS = CTX_W'(NUM_CTX - 1);

    // Step the pointer with wrap-around on every completion in normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST_POS) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/pos_req_bit.sv
// Module: host priority request bit. The host sets it and the hardware
// clears it. A set in the same cycle as a clear wins, so a request is
// never lost. Assumes set and clr are single-cycle pulses.
module pos_req_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the request; a set takes precedence over the end-of-walk clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/pos_list_walker.sv
// Module: priority list walker. Once started, it fetches list words one
// at a time, serves active entries until svc_done, and passes over the
// inactive ones. It stops at the end flag or after LIST_MAX entries.
// Assumes the memory keeps rd_data valid during the rd_valid cycle and
// that rd_valid only rises while rd_req is high.
module pos_list_walker
    import pos_sched_pkg::*;
#(
    parameter int              LIST_MAX  = 256,
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] LIST_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              svc_done,
    input  logic              rd_valid,
    input  logic [15:0]       rd_data,
    output walk_state_e       state,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CTX_W-1:0]  pri_idx,
    output logic              walk_done
);
    localparam int ENT_W = (LIST_MAX > 1) ? $clog2(LIST_MAX) : 1;
    localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(LIST_MAX - 1);

    logic [ENT_W-1:0] ent;
    logic             fin_q;
    prio_entry_t      word;
    logic             final_here;

    // Decode the returned word and decide whether it closes the list.
    always_comb begin
        word       = prio_entry_t'(rd_data);
        final_here = word.last || (ent == LAST_ENT);
    end

    // Drive the read port and flag the cycle in which the walk ends.
    always_comb begin
        rd_req    = (state == WALK_FETCH);
        rd_addr   = LIST_BASE + (ADDR_W'(ent) << 1);
        walk_done = ((state == WALK_FETCH) && rd_valid && !word.active && final_here)
                 || ((state == WALK_SERVE) && svc_done && fin_q);
    end

    // Sequence fetch and serve phases and step the list position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= WALK_IDLE;
            ent     <= '0;
            pri_idx <= '0;
            fin_q   <= 1'b0;
        end else begin
            case (state)
                WALK_IDLE: begin
                    if (start) begin
                        state <= WALK_FETCH;
                        ent   <= '0;
                    end
                end
                WALK_FETCH: begin
                    if (rd_valid) begin
                        if (word.active) begin
                            state   <= WALK_SERVE;
                            pri_idx <= word.ctx;
                            fin_q   <= final_here;
                        end else if (final_here) begin
                            state <= WALK_IDLE;
                        end else begin
                            ent <= ent + 1'b1;
                        end
                    end
                end
                WALK_SERVE: begin
                    if (svc_done) begin
                        if (fin_q) begin
                            state <= WALK_IDLE;
                        end else begin
                            state <= WALK_FETCH;
                            ent   <= ent + 1'b1;
                        end
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pos_sched.sv
// Module: top of the priority override channel scheduler. It combines
// the normal round-robin pointer, the host request bit and the list
// walker, and presents the channel to serve. A priority walk only
// begins at a normal-channel completion.
// Assumes svc_done is a single-cycle pulse per completed channel.
module pos_sched
    import pos_sched_pkg::*;
#(
    parameter int                NUM_CTX   = 8,
    parameter int                LIST_MAX  = 256,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] LIST_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prio_set,
    output logic              prio_req,
    input  logic              svc_done,
    output logic              serve_vld,
    output logic              serve_prio,
    output logic [12:0]       serve_idx,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [15:0]       rd_data
);
    walk_state_e      state;
    logic [CTX_W-1:0] ctx_ptr;
    logic [CTX_W-1:0] pri_idx;
    logic             in_normal;
    logic             adv;
    logic             start;
    logic             walk_done;

    // Normal completions advance the table; with a request pending they start a walk.
    always_comb begin
        in_normal = (state == WALK_IDLE);
        adv       = in_normal && svc_done;
        start     = adv && prio_req;
    end

    pos_ctx_ring #(
        .NUM_CTX (NUM_CTX),
        .CTX_W   (CTX_W)
    ) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .ptr   (ctx_ptr)
    );

    pos_req_bit u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (prio_set),
        .clr   (walk_done),
        .q     (prio_req)
    );

    pos_list_walker #(
        .LIST_MAX  (LIST_MAX),
        .ADDR_W    (ADDR_W),
        .LIST_BASE (LIST_BASE)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .svc_done  (svc_done),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .state     (state),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .pri_idx   (pri_idx),
        .walk_done (walk_done)
    );

    // Present either the priority entry or the normal table position.
    always_comb begin
        serve_vld  = (state != WALK_FETCH);
        serve_prio = (state == WALK_SERVE);
        serve_idx  = serve_prio ? pri_idx : ctx_ptr;
    end
endmodule

// File: rtl/pos_sched_chk.sv
// Module: assertion checker for pos_sched, attached by bind below.
// It watches the ports plus the normal pointer and the end-of-walk flag.
module pos_sched_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prio_set,
    input logic              prio_req,
    input logic              svc_done,
    input logic              serve_vld,
    input logic              serve_prio,
    input logic [12:0]       serve_idx,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic [12:0]       ctx_ptr,
    input logic              walk_done
);
    // R3: a normal channel keeps its slot until its completion arrives.
    assert_hold_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (serve_vld && !serve_prio && !svc_done) |=> (serve_vld && !serve_prio && $stable(serve_idx)));

    // R3: list activity only happens with the request bit set.
    assert_walk_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || serve_prio) |-> prio_req);

    // R4: an outstanding read keeps its request and address.
    assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R5: a priority entry stays in service until svc_done.
    assert_serve_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (serve_prio && !svc_done) |=> (serve_prio && $stable(serve_idx)));

    // R9: the request bit only drops at the end of a walk.
    assert_clear_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prio_req) |-> $past(walk_done));

    // R10: the saved normal position is frozen during a walk.
    assert_ctx_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || serve_prio) |=> $stable(ctx_ptr));

    // R11: a host set that coincides with the end-of-walk clear wins.
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && prio_set) |=> prio_req);
endmodule

bind pos_sched pos_sched_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prio_set   (prio_set),
    .prio_req   (prio_req),
    .svc_done   (svc_done),
    .serve_vld  (serve_vld),
    .serve_prio (serve_prio),
    .serve_idx  (serve_idx),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .ctx_ptr    (ctx_ptr),
    .walk_done  (walk_done)
);

// File: tb/pos_sched_bench.sv
`timescale 1ns/1ps
// Directed bench for pos_sched: one task per scenario, each checking its own results.
module pos_sched_bench;
    localparam int          NCTX = 8;
    localparam logic [15:0] BASE = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prio_set = 1'b0;
    logic        prio_req;
    logic        svc_done = 1'b0;
    logic        serve_vld;
    logic        serve_prio;
    logic [12:0] serve_idx;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = 16'h0;

    int vectors = 0;
    int miscomp = 0;
    int exp_ctx = 0;
    int lat = 0;
    int fetch_cnt = 0;
    logic [15:0] last_addr = 16'h0;
    logic [15:0] mem [256];

    always #2 clk = ~clk;

    pos_sched u_pos_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .prio_set   (prio_set),
        .prio_req   (prio_req),
        .svc_done   (svc_done),
        .serve_vld  (serve_vld),
        .serve_prio (serve_prio),
        .serve_idx  (serve_idx),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    // List memory model: answers a held request after lat idle cycles.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n || rd_valid) begin
                rd_valid = 1'b0;
                cnt = 0;
            end else if (rd_req) begin
                if (cnt >= lat) begin
                    rd_valid  = 1'b1;
                    rd_data   = mem[8'((rd_addr - BASE) >> 1)];
                    last_addr = rd_addr;
                    fetch_cnt++;
                end else begin
                    cnt++;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    function automatic logic [15:0] entry(int idx, bit last, bit act);
        return {13'(idx), 1'b0, last, act};
    endfunction

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscomp++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        fetch_cnt = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk) svc_done = 1'b1;
        @(negedge clk) svc_done = 1'b0;
    endtask

    task automatic set_prio();
        @(negedge clk) prio_set = 1'b1;
        @(negedge clk) prio_set = 1'b0;
    endtask

    task automatic wait_prio(string req);
        int n = 0;
        while (!(serve_vld && serve_prio) && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(req, int'(serve_prio), 1);
    endtask

    task automatic wait_clear(string req, output bit saw_prio);
        int n = 0;
        saw_prio = 1'b0;
        while (prio_req && n < 2000) begin
            if (serve_prio) saw_prio = 1'b1;
            @(negedge clk);
            n++;
        end
        chk(req, int'(prio_req), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 idx", int'(serve_idx), 0);
        chk("R1 vld", int'(serve_vld), 1);
        chk("R1 prio", int'(serve_prio), 0);
        chk("R1 req", int'(prio_req), 0);
        chk("R1 rdreq", int'(rd_req), 0);
        exp_ctx = 0;
    endtask

    task automatic t_round_robin();
        for (int i = 1; i <= NCTX + 1; i++) begin
            pulse_done();
            exp_ctx = i % NCTX;
            chk("R2 rr step", int'(serve_idx), exp_ctx);
        end
    endtask

    task automatic t_basic_walk();
        clear_mem();
        lat = 3;
        mem[0] = entry(100, 0, 1) | 16'h0004; // bit 2 set, must be ignored (R5)
        mem[1] = entry(55, 0, 0);
        mem[2] = entry(200, 1, 1);
        set_prio();
        chk("R3 req set", int'(prio_req), 1);
        repeat (3) @(negedge clk);
        chk("R3 no preempt idx", int'(serve_idx), exp_ctx);
        chk("R3 no preempt mode", int'(serve_prio), 0);
        pulse_done();
        exp_ctx = (exp_ctx + 1) % NCTX;
        chk("R4 rd_req", int'(rd_req), 1);
        chk("R4 vld low", int'(serve_vld), 0);
        chk("R4 addr0", int'(rd_addr), int'(BASE));
        @(negedge clk);
        chk("R4 addr held", int'(rd_addr), int'(BASE));
        wait_prio("R5 served");
        chk("R5 idx", int'(serve_idx), 100);
        repeat (4) @(negedge clk);
        chk("R5 held", int'(serve_idx), 100);
        pulse_done();
        wait_prio("R6 next served");
        chk("R6 skip idx", int'(serve_idx), 200);
        chk("R6 reads", fetch_cnt, 3);
        chk("R4 addr2", int'(last_addr), int'(BASE) + 4);
        pulse_done();
        chk("R9 req clr", int'(prio_req), 0);
        chk("R9 mode", int'(serve_prio), 0);
        chk("R9 resume", int'(serve_idx), exp_ctx);
    endtask

    task automatic t_end_inactive();
        bit saw;
        clear_mem();
        lat = 1;
        mem[0] = entry(3, 0, 0);
        mem[1] = entry(9, 1, 0);
        mem[2] = entry(33, 0, 1);
        set_prio();
        pulse_done();
        exp_ctx = (exp_ctx + 1) % NCTX;
        wait_clear("R7 walk ends", saw);
        chk("R7 nothing served", int'(saw), 0);
        chk("R7 reads", fetch_cnt, 2);
        chk("R9 resume", int'(serve_idx), exp_ctx);
    endtask

    task automatic t_no_end();
        bit saw;
        clear_mem();
        lat = 0;
        set_prio();
        pulse_done();
        exp_ctx = (exp_ctx + 1) % NCTX;
        wait_clear("R8 walk ends", saw);
        chk("R8 reads", fetch_cnt, 256);
        chk("R8 last addr", int'(last_addr), int'(BASE) + 510);
        chk("R8 resume", int'(serve_idx), exp_ctx);
    endtask

    task automatic t_done_in_fetch();
        clear_mem();
        lat = 6;
        mem[0] = entry(77, 1, 1);
        set_prio();
        pulse_done();
        exp_ctx = (exp_ctx + 1) % NCTX;
        pulse_done(); // arrives while entry 0 is outstanding
        chk("R10 still fetching", int'(rd_req), 1);
        wait_prio("R10 entry served");
        chk("R10 entry idx", int'(serve_idx), 77);
        chk("R10 reads", fetch_cnt, 1);
        pulse_done();
        chk("R10 normal pos", int'(serve_idx), exp_ctx);
    endtask

    task automatic t_collide();
        clear_mem();
        lat = 2;
        mem[0] = entry(7, 1, 1);
        set_prio();
        pulse_done();
        exp_ctx = (exp_ctx + 1) % NCTX;
        wait_prio("R11 first walk");
        @(negedge clk);
        svc_done = 1'b1;
        prio_set = 1'b1;
        @(negedge clk);
        svc_done = 1'b0;
        prio_set = 1'b0;
        chk("R11 req kept", int'(prio_req), 1);
        chk("R11 normal mode", int'(serve_prio), 0);
        chk("R11 normal idx", int'(serve_idx), exp_ctx);
        fetch_cnt = 0;
        pulse_done();
        exp_ctx = (exp_ctx + 1) % NCTX;
        chk("R11 refetch", int'(rd_req), 1);
        chk("R11 refetch addr", int'(rd_addr), int'(BASE));
        wait_prio("R11 second walk");
        chk("R11 idx", int'(serve_idx), 7);
        pulse_done();
        chk("R11 req clr", int'(prio_req), 0);
        chk("R11 resume", int'(serve_idx), exp_ctx);
    endtask

    task automatic t_reset_midwalk();
        clear_mem();
        lat = 1;
        mem[0] = entry(42, 1, 1);
        set_prio();
        pulse_done();
        wait_prio("R1 walk before reset");
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid idx", int'(serve_idx), 0);
        chk("R1 mid prio", int'(serve_prio), 0);
        chk("R1 mid req", int'(prio_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mid rdreq", int'(rd_req), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscomp++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        clear_mem();
        t_reset();
        t_round_robin();
        t_basic_walk();
        t_end_inactive();
        t_no_end();
        t_done_in_fetch();
        t_collide();
        t_reset_midwalk();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule